// File: doc/BRIEF.md
# Single-Cycle 16-Bit Harvard Processor Core

This block is a small processor core that completes one 16-bit instruction on every clock edge. It holds its own program store, a program counter with relative branch and jump logic, a combinational decoder that turns each instruction word into a datapath control word, an eight-entry register file, an ALU that reports overflow, carry, negative and zero flags, the operand and write-back selectors, and a data store. Program and data sit in separate arrays, so fetching an instruction and reading or writing data happen in the same cycle.

The program store is filled through a write port, normally while reset is held. Once reset is released, execution starts at address 0. The register write and the data-store write of the instruction in flight are shown on two observation buses, and the current program counter is driven out, so the core's progress can be followed at its ports.

Top module: `cpu_core`

## Requirements
- R1: Every instruction word has its opcode in bits 15..9. Bits 15..13 give the category and bits 12..9 give the function. Category 000 is register ALU: it writes DR (bits 8..6) with f(SA, SB), where SA is bits 5..3 and SB is bits 2..0.
- R2: Function codes: 0000 passes A, 0001 gives A+1, 0010 gives A+B, 0101 gives A−B, 1000 AND, 1001 OR, 1010 XOR, 1011 NOT A, 1100 shifts A right by one with a zero fill, and 1101 shifts A left by one with a zero fill. Any other code gives zero.
- R3: Category 001 is immediate ALU. It works like R1, but the B operand is bits 2..0 zero-extended to 16 bits.
- R4: Category 010 loads DR from the data word addressed by the low bits of register SA. Category 011 stores register SB at the address in register SA and writes no register. A store and a register write never occur together.
- R5: Reset sets the PC and all eight registers to zero, and no write occurs while reset is asserted. Register 0 is an ordinary register that can be written.
- R6: Category 110 is a branch. SA passes through the ALU, and bits 10..9 pick a flag: 00 Z, 01 N, 10 C, 11 V. Bit 11 set inverts the test. When taken, the PC becomes PC plus the sign-extended 6-bit offset {bits 8..6, bits 2..0}; otherwise it becomes PC+1. A branch writes no register.
- R7: Category 111 is an unconditional jump. The PC becomes PC plus the same sign-extended offset, and no register is written.
- R8: Categories 100 and 101 write nothing and advance the PC by one. Every non-transfer instruction advances the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we_i | input | 1 | Program store write enable |
| imem_addr_i | input | 6 | Program store write address |
| imem_data_i | input | 16 | Program store write data |
| pc_o | output | 6 | Address of the instruction executing this cycle |
| wb_en_o | output | 1 | Register write happening this cycle |
| wb_addr_o | output | 3 | Register being written |
| wb_data_o | output | 16 | Value being written |
| st_en_o | output | 1 | Data store write happening this cycle |
| st_addr_o | output | 4 | Data store address being written |
| st_data_o | output | 16 | Data being stored |

## Verification
The register write and the store of an instruction appear on the observation buses in the same cycle that the PC points at it, with no register in between. The effect of a branch or jump shows up as the PC value one clock edge later. The scoreboard therefore holds one expected entry per executed instruction: a PC value, plus any write that instruction makes. It samples shortly after each falling edge, when the edge-updated PC and the combinational buses have both settled. Skipped instructions have no entry, so a wrong branch decision shows as a PC mismatch on the very next entry.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int DATA_W   = 16;
    localparam int INSTR_W  = 16;
    localparam int REG_AW   = 3;
    localparam int OFFS_W   = 6;
    localparam int IMM_W    = 3;

    typedef enum logic [2:0] {
        CAT_REG    = 3'b000,
        CAT_IMM    = 3'b001,
        CAT_LOAD   = 3'b010,
        CAT_STORE  = 3'b011,
        CAT_BRANCH = 3'b110,
        CAT_JUMP   = 3'b111
    } cat_e;

    typedef enum logic [3:0] {
        FS_PASS = 4'b0000,
        FS_INC  = 4'b0001,
        FS_ADD  = 4'b0010,
        FS_SUB  = 4'b0101,
        FS_AND  = 4'b1000,
        FS_OR   = 4'b1001,
        FS_XOR  = 4'b1010,
        FS_NOT  = 4'b1011,
        FS_SHR  = 4'b1100,
        FS_SHL  = 4'b1101
    } fs_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;

    typedef struct packed {
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        logic              use_imm;
        fs_e               fn;
        logic              from_mem;
        logic              reg_we;
        logic              mem_we;
        logic              is_branch;
        logic              is_jump;
        logic [2:0]        cond;
    } ctrl_t;

    function automatic logic [OFFS_W-1:0] offset_field(input logic [INSTR_W-1:0] ins);
        return {ins[8:6], ins[2:0]};
    endfunction

endpackage

// File: rtl/cpu_decoder.sv
module cpu_decoder
    import cpu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output ctrl_t              ctrl_o
);

    always_comb begin
        ctrl_o           = '0;
        ctrl_o.dst       = instr_i[8:6];
        ctrl_o.src_a     = instr_i[5:3];
        ctrl_o.src_b     = instr_i[2:0];
        ctrl_o.fn        = FS_PASS;
        ctrl_o.cond      = instr_i[11:9];
        case (cat_e'(instr_i[15:13]))
            CAT_REG: begin
                ctrl_o.fn     = fs_e'(instr_i[12:9]);
                ctrl_o.reg_we = 1'b1;
            end
            CAT_IMM: begin
                ctrl_o.fn      = fs_e'(instr_i[12:9]);
                ctrl_o.use_imm = 1'b1;
                ctrl_o.reg_we  = 1'b1;
            end
            CAT_LOAD: begin
                ctrl_o.from_mem = 1'b1;
                ctrl_o.reg_we   = 1'b1;
            end
            CAT_STORE:  ctrl_o.mem_we    = 1'b1;
            CAT_BRANCH: ctrl_o.is_branch = 1'b1;
            CAT_JUMP:   ctrl_o.is_jump   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [DW-1:0] wd_i,
    input  logic [AW-1:0] ra_i,
    input  logic [AW-1:0] rb_i,
    output logic [DW-1:0] rd_a_o,
    output logic [DW-1:0] rd_b_o
);

    localparam int NREG = 2 ** AW;

    logic [DW-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we_i) begin
            regs_q[wa_i] <= wd_i;
        end
    end

    assign rd_a_o = regs_q[ra_i];
    assign rd_b_o = regs_q[rb_i];

    AST_RF_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_o == '0 && rd_b_o == '0)); // R5

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  fs_e               fn_i,
    output logic [DATA_W-1:0] y_o,
    output flags_t            fl_o
);

    logic [DATA_W:0] sum;
    logic            ovf;

    always_comb begin
        sum = '0;
        ovf = 1'b0;
        y_o = '0;
        case (fn_i)
            FS_PASS: y_o = a_i;
            FS_INC: begin
                sum = {1'b0, a_i} + {{DATA_W{1'b0}}, 1'b1};
                y_o = sum[DATA_W-1:0];
                ovf = !a_i[DATA_W-1] && y_o[DATA_W-1];
            end
            FS_ADD: begin
                sum = {1'b0, a_i} + {1'b0, b_i};
                y_o = sum[DATA_W-1:0];
                ovf = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (y_o[DATA_W-1] != a_i[DATA_W-1]);
            end
            FS_SUB: begin
                sum = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
                y_o = sum[DATA_W-1:0];
                ovf = (a_i[DATA_W-1] != b_i[DATA_W-1]) && (y_o[DATA_W-1] != a_i[DATA_W-1]);
            end
            FS_AND:  y_o = a_i & b_i;
            FS_OR:   y_o = a_i | b_i;
            FS_XOR:  y_o = a_i ^ b_i;
            FS_NOT:  y_o = ~a_i;
            FS_SHR:  y_o = {1'b0, a_i[DATA_W-1:1]};
            FS_SHL:  y_o = {a_i[DATA_W-2:0], 1'b0};
            default: y_o = '0;
        endcase
        fl_o.v = ovf;
        fl_o.c = sum[DATA_W];
        fl_o.n = y_o[DATA_W-1];
        fl_o.z = (y_o == '0);
    end

endmodule

// File: rtl/cpu_next_pc.sv
module cpu_next_pc
    import cpu_pkg::*;
#(
    parameter int PW = 6
) (
    input  logic [PW-1:0]     pc_i,
    input  logic              is_branch_i,
    input  logic              is_jump_i,
    input  logic [2:0]        cond_i,
    input  flags_t            fl_i,
    input  logic [OFFS_W-1:0] offs_i,
    output logic [PW-1:0]     pc_next_o
);

    logic              flag_sel;
    logic              take;
    logic signed [OFFS_W-1:0] offs_s;

    always_comb begin
        case (cond_i[1:0])
            2'b00:   flag_sel = fl_i.z;
            2'b01:   flag_sel = fl_i.n;
            2'b10:   flag_sel = fl_i.c;
            default: flag_sel = fl_i.v;
        endcase
        take   = is_jump_i || (is_branch_i && (flag_sel ^ cond_i[2]));
        offs_s = $signed(offs_i);
        pc_next_o = take ? (pc_i + PW'(offs_s)) : (pc_i + PW'(1));
    end

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               imem_we_i,
    input  logic [IMEM_AW-1:0] imem_addr_i,
    input  logic [INSTR_W-1:0] imem_data_i,
    output logic [IMEM_AW-1:0] pc_o,
    output logic               wb_en_o,
    output logic [REG_AW-1:0]  wb_addr_o,
    output logic [DATA_W-1:0]  wb_data_o,
    output logic               st_en_o,
    output logic [DMEM_AW-1:0] st_addr_o,
    output logic [DATA_W-1:0]  st_data_o
);

    localparam int IMEM_DEPTH = 2 ** IMEM_AW;
    localparam int DMEM_DEPTH = 2 ** DMEM_AW;

    logic [INSTR_W-1:0] imem [IMEM_DEPTH];
    logic [DATA_W-1:0]  dmem [DMEM_DEPTH];

    logic [IMEM_AW-1:0] pc_q, pc_next;
    logic [INSTR_W-1:0] instr;
    ctrl_t              ctrl;
    logic [DATA_W-1:0]  rd_a, rd_b, opnd_b, alu_y, mem_rd, wb_val;
    logic [DMEM_AW-1:0] d_addr;
    flags_t             flags;
    logic               rf_we, dm_we;

    // program store: written through the load port, read asynchronously
    always_ff @(posedge clk) begin
        if (imem_we_i) imem[imem_addr_i] <= imem_data_i;
    end
    assign instr = imem[pc_q];

    cpu_decoder i_dec (
        .instr_i (instr),
        .ctrl_o  (ctrl)
    );

    assign rf_we = ctrl.reg_we && !rst;
    assign dm_we = ctrl.mem_we && !rst;

    cpu_regfile #(.AW(REG_AW), .DW(DATA_W)) i_rf (
        .clk    (clk),
        .rst    (rst),
        .we_i   (rf_we),
        .wa_i   (ctrl.dst),
        .wd_i   (wb_val),
        .ra_i   (ctrl.src_a),
        .rb_i   (ctrl.src_b),
        .rd_a_o (rd_a),
        .rd_b_o (rd_b)
    );

    assign opnd_b = ctrl.use_imm ? DATA_W'(instr[IMM_W-1:0]) : rd_b;

    cpu_alu i_alu (
        .a_i  (rd_a),
        .b_i  (opnd_b),
        .fn_i (ctrl.fn),
        .y_o  (alu_y),
        .fl_o (flags)
    );

    // data store: asynchronous read, synchronous write, cleared by reset
    assign d_addr = rd_a[DMEM_AW-1:0];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DMEM_DEPTH; i++) dmem[i] <= '0;
        end else if (dm_we) begin
            dmem[d_addr] <= rd_b;
        end
    end
    assign mem_rd = dmem[d_addr];
    assign wb_val = ctrl.from_mem ? mem_rd : alu_y;

    cpu_next_pc #(.PW(IMEM_AW)) i_npc (
        .pc_i        (pc_q),
        .is_branch_i (ctrl.is_branch),
        .is_jump_i   (ctrl.is_jump),
        .cond_i      (ctrl.cond),
        .fl_i        (flags),
        .offs_i      (offset_field(instr)),
        .pc_next_o   (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o      = pc_q;
    assign wb_en_o   = rf_we;
    assign wb_addr_o = ctrl.dst;
    assign wb_data_o = wb_val;
    assign st_en_o   = dm_we;
    assign st_addr_o = d_addr;
    assign st_data_o = rd_b;

    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(st_en_o && wb_en_o)); // R4
    AST_XFER_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (instr[15:14] == 2'b11) |-> !wb_en_o); // R6
    AST_IMM_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (instr[15:13] == 3'b001) |-> (opnd_b < DATA_W'(8))); // R3
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(instr[15:14]) != 2'b11)) |-> (pc_q == $past(pc_q) + 1'b1)); // R8

endmodule

// File: tb/test_cpu_core.sv
module test_cpu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_addr = '0;
    logic [15:0] imem_data = '0;
    logic [5:0]  pc;
    logic        wb_en, st_en;
    logic [2:0]  wb_addr;
    logic [15:0] wb_data, st_data;
    logic [3:0]  st_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit running = 1'b0;
    bit done    = 1'b0;

    typedef struct {
        int    pc;
        bit    wen;
        int    wa;
        int    wd;
        bit    sen;
        int    sa;
        int    sd;
        string tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    cpu_core i_cpu_core (
        .clk         (clk),
        .rst         (rst),
        .imem_we_i   (imem_we),
        .imem_addr_i (imem_addr),
        .imem_data_i (imem_data),
        .pc_o        (pc),
        .wb_en_o     (wb_en),
        .wb_addr_o   (wb_addr),
        .wb_data_o   (wb_data),
        .st_en_o     (st_en),
        .st_addr_o   (st_addr),
        .st_data_o   (st_data)
    );

    function automatic logic [15:0] rr(input logic [6:0] op, input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
        return {op, d, a, b};
    endfunction

    function automatic logic [15:0] bj(input logic [6:0] op, input logic [2:0] a, input logic [5:0] ad);
        return {op, ad[5:3], a, ad[2:0]};
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int p, input bit wen, input int wa, input int wd,
                        input bit sen, input int sa, input int sd, input string tag);
        exp_t e;
        e.pc = p; e.wen = wen; e.wa = wa; e.wd = wd;
        e.sen = sen; e.sa = sa; e.sd = sd; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: one expected entry per executed instruction
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (running && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "pc", int'(pc), e.pc);
                chk(e.tag, "wb_en", int'(wb_en), int'(e.wen));
                if (e.wen) begin
                    chk(e.tag, "wb_addr", int'(wb_addr), e.wa);
                    chk(e.tag, "wb_data", int'(wb_data), e.wd);
                end
                chk(e.tag, "st_en", int'(st_en), int'(e.sen));
                if (e.sen) begin
                    chk(e.tag, "st_addr", int'(st_addr), e.sa);
                    chk(e.tag, "st_data", int'(st_data), e.sd);
                end
                if (q.size() == 0) done = 1'b1;
            end
        end
    end

    initial begin
        logic [15:0] prog [64];
        for (int i = 0; i < 64; i++) prog[i] = 16'h8000;      // category 100
        prog[0]  = rr(7'h12, 3'd1, 3'd0, 3'd5);   // ADDI R1,R0,#5
        prog[1]  = rr(7'h12, 3'd2, 3'd0, 3'd7);   // ADDI R2,R0,#7
        prog[2]  = rr(7'h02, 3'd3, 3'd1, 3'd2);   // ADD  R3,R1,R2
        prog[3]  = rr(7'h05, 3'd4, 3'd1, 3'd2);   // SUB  R4,R1,R2
        prog[4]  = rr(7'h01, 3'd4, 3'd4, 3'd0);   // INC  R4
        prog[5]  = rr(7'h08, 3'd5, 3'd3, 3'd2);   // AND
        prog[6]  = rr(7'h09, 3'd5, 3'd5, 3'd1);   // OR
        prog[7]  = rr(7'h0A, 3'd6, 3'd3, 3'd1);   // XOR
        prog[8]  = rr(7'h0B, 3'd6, 3'd6, 3'd0);   // NOT
        prog[9]  = rr(7'h0D, 3'd7, 3'd3, 3'd0);   // SHL
        prog[10] = rr(7'h0C, 3'd7, 3'd7, 3'd0);   // SHR
        prog[11] = rr(7'h30, 3'd0, 3'd1, 3'd3);   // ST [R1],R3
        prog[12] = rr(7'h20, 3'd0, 3'd1, 3'd0);   // LD R0,[R1]
        prog[13] = rr(7'h00, 3'd7, 3'd0, 3'd0);   // PASS R7,R0
        prog[14] = bj(7'h64, 3'd4, 6'd3);         // BNZ R4,+3
        prog[15] = rr(7'h12, 3'd1, 3'd1, 3'd1);   // skipped
        prog[16] = rr(7'h12, 3'd1, 3'd1, 3'd1);   // skipped
        prog[17] = bj(7'h60, 3'd4, 6'd5);         // BZ R4,+5 (not taken)
        prog[18] = bj(7'h61, 3'd4, 6'd2);         // BN R4,+2 (taken)
        prog[19] = rr(7'h12, 3'd1, 3'd1, 3'd1);   // skipped
        prog[20] = rr(7'h40, 3'd1, 3'd1, 3'd1);   // category 100: no effect
        prog[21] = rr(7'h12, 3'd2, 3'd1, 3'd7);   // ADDI R2,R1,#7
        prog[22] = bj(7'h70, 3'd0, 6'b111111);    // JMP -1

        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            imem_we   = 1'b1;
            imem_addr = 6'(i);
            imem_data = prog[i];
        end
        @(negedge clk);
        imem_we = 1'b0;
        @(negedge clk);
        #1;
        chk("R5", "reset pc", int'(pc), 0);
        chk("R5", "reset wb_en", int'(wb_en), 0);
        chk("R5", "reset st_en", int'(st_en), 0);

        push(0,  1, 1, 16'h0005, 0, 0, 0, "R3");
        push(1,  1, 2, 16'h0007, 0, 0, 0, "R3");
        push(2,  1, 3, 16'h000C, 0, 0, 0, "R1");
        push(3,  1, 4, 16'hFFFE, 0, 0, 0, "R2");
        push(4,  1, 4, 16'hFFFF, 0, 0, 0, "R2");
        push(5,  1, 5, 16'h0004, 0, 0, 0, "R2");
        push(6,  1, 5, 16'h0005, 0, 0, 0, "R2");
        push(7,  1, 6, 16'h0009, 0, 0, 0, "R2");
        push(8,  1, 6, 16'hFFF6, 0, 0, 0, "R2");
        push(9,  1, 7, 16'h0018, 0, 0, 0, "R2");
        push(10, 1, 7, 16'h000C, 0, 0, 0, "R2");
        push(11, 0, 0, 0,        1, 5, 16'h000C, "R4");
        push(12, 1, 0, 16'h000C, 0, 0, 0, "R4");
        push(13, 1, 7, 16'h000C, 0, 0, 0, "R5");
        push(14, 0, 0, 0,        0, 0, 0, "R6");
        push(17, 0, 0, 0,        0, 0, 0, "R6");
        push(18, 0, 0, 0,        0, 0, 0, "R6");
        push(20, 0, 0, 0,        0, 0, 0, "R6");
        push(21, 1, 2, 16'h000C, 0, 0, 0, "R8");
        push(22, 0, 0, 0,        0, 0, 0, "R7");
        push(21, 1, 2, 16'h000C, 0, 0, 0, "R7");
        push(22, 0, 0, 0,        0, 0, 0, "R7");
        push(21, 1, 2, 16'h000C, 0, 0, 0, "R7");

        rst = 1'b0;
        running = 1'b1;
    end

    // watchdog
    initial begin
        int cycles = 0;
        while (!done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule